// File: doc/BRIEF.md
# Receive Error Statistics Counters

This block sits beside a receive MAC and keeps two 16-bit event counters. The first counts false-carrier events: a carrier attempt that signals an error code on the nibble-wide receive bus while no frame is being delivered. The second counts undersize frames: frames that are too short but otherwise clean, meaning the check sequence is good, the frame is well formed and no length error is flagged. The MAC supplies one status strobe per received frame, carrying the length and the quality flags.

False-carrier detection is decoupled from counting. A detected event is latched as pending, and at most one is latched per inter-frame gap. It reaches the counter only at the status strobe of the next received frame, so both counters move together with that frame's statistics. The status strobe is a one-cycle valid with no ready: the block accepts a strobe on every cycle, back-to-back included, and never applies back-pressure. Software reads and writes each counter through a one-bit select and a 32-bit data word. Reads are combinational, and writes take effect on the next clock edge.

Top module: `rx_err_stats`

## Requirements
- R1: A false-carrier hit is a cycle with `rx_er` = 1, `rx_dv` = 0 and `rxd` = 4'hE. Any other combination, including code 4'hE while `rx_dv` = 1, is not a hit.
- R2: At most one hit is captured per gap. After a capture, further hits are ignored until a cycle with `rx_dv` = 1 has been seen. This holds however often the condition toggles within the gap.
- R3: A captured event does not change the count when it is detected. It adds one to the false-carrier counter on the next `st_valid` strobe, and that strobe clears the pending event. A strobe with nothing pending adds nothing.
- R4: A strobe with `st_len` < 64, `st_fcs_ok` = 1 and `st_well_formed` = 1 increments the undersize counter. A length of 64 or more, a bad check sequence or a malformed frame does not.
- R5: A strobe with `st_len_err` = 1 never increments the undersize counter.
- R6: `reg_sel` = 0 selects the false-carrier counter and `reg_sel` = 1 selects the undersize counter. `reg_rdata[15:0]` shows the selected counter and `reg_rdata[31:16]` reads as zero. Both counters are zero after reset.
- R7: A cycle with `reg_wr` = 1 loads `reg_wdata[15:0]` into the selected counter. `reg_wdata[31:16]` is ignored.
- R8: Each counter saturates at 16'hFFFF and never wraps.
- R9: A write and a hardware increment to the same counter in the same cycle leave the written value. A false-carrier commit that coincides with a write still clears the pending event.
- R10: Strobes in consecutive cycles are each counted, and there is no ready signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| rxd | input | 4 | Receive data nibble |
| st_valid | input | 1 | Per-frame status strobe |
| st_len | input | 16 | Frame length in bytes |
| st_fcs_ok | input | 1 | Check sequence correct |
| st_well_formed | input | 1 | Frame otherwise well formed |
| st_len_err | input | 1 | Length/range error |
| reg_sel | input | 1 | Counter select (0 false carrier, 1 undersize) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected counter |

## Verification
The hardest situations to reach are those where state already pending meets a new event in the same cycle. One case is a software write that lands on the very strobe that commits a pending false carrier. Another is a repeated error burst inside one gap, which must still be counted only once. The stimulus builds these cases in explicit phases: it first creates the pending event, then issues the write and the strobe on the same clock edge. It then sends a further frame with its strobe to show that nothing leaked through. Saturation is reached by preloading a counter to just below full through the write path.

// File: rtl/rx_err_stats_pkg.sv
package rx_err_stats_pkg;
  localparam logic [3:0] FALSE_CARRIER_CODE = 4'hE;
  localparam int NUM_COUNTERS = 2;
  typedef enum logic {
    SEL_FALSE_CARRIER = 1'b0,
    SEL_UNDERSIZE     = 1'b1
  } stat_sel_e;
endpackage

// File: rtl/rx_fc_tracker.sv
module rx_fc_tracker
  import rx_err_stats_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic [3:0] rxd,
  input  logic       commit,
  output logic       fc_inc
);
  logic pending_q, gap_lock_q;
  logic hit, capture;

  assign hit     = rx_er && !rx_dv && (rxd == FALSE_CARRIER_CODE);
  assign capture = hit && !gap_lock_q;
  assign fc_inc  = commit && pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      gap_lock_q <= 1'b0;
    end else begin
      if (rx_dv)        gap_lock_q <= 1'b0;
      else if (capture) gap_lock_q <= 1'b1;
      if (capture)      pending_q  <= 1'b1;
      else if (commit)  pending_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_undersize_qual.sv
module rx_undersize_qual #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             st_valid,
  input  logic [LEN_W-1:0] st_len,
  input  logic             st_fcs_ok,
  input  logic             st_well_formed,
  input  logic             st_len_err,
  output logic             und_inc
);
  localparam logic [LEN_W-1:0] MinLenV = LEN_W'(MIN_LEN);
  assign und_inc = st_valid && (st_len < MinLenV) && st_fcs_ok
                   && st_well_formed && !st_len_err;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] Full = '1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (load)                count <= load_val;
    else if (inc && count != Full) count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
  import rx_err_stats_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int REG_W   = 32,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic [3:0]       rxd,
  input  logic             st_valid,
  input  logic [LEN_W-1:0] st_len,
  input  logic             st_fcs_ok,
  input  logic             st_well_formed,
  input  logic             st_len_err,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  logic [NUM_COUNTERS-1:0] inc_vec, load_vec;
  logic [CNT_W-1:0]        cnt [NUM_COUNTERS];
  logic                    fc_inc, und_inc;

  rx_fc_tracker u_fc (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .commit(st_valid), .fc_inc(fc_inc)
  );

  rx_undersize_qual #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_und (
    .st_valid(st_valid), .st_len(st_len), .st_fcs_ok(st_fcs_ok),
    .st_well_formed(st_well_formed), .st_len_err(st_len_err), .und_inc(und_inc)
  );

  always_comb begin
    inc_vec = '0;
    inc_vec[SEL_FALSE_CARRIER] = fc_inc;
    inc_vec[SEL_UNDERSIZE]     = und_inc;
    load_vec = '0;
    load_vec[reg_sel] = reg_wr;
  end

  for (genvar g = 0; g < NUM_COUNTERS; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load_vec[g]),
      .load_val(reg_wdata[CNT_W-1:0]), .inc(inc_vec[g]), .count(cnt[g])
    );
  end

  assign reg_rdata = REG_W'(cnt[reg_sel]);
endmodule

// File: rtl/rx_err_stats_chk.sv
module rx_err_stats_chk #(
  parameter int CNT_W = 16,
  parameter int REG_W = 32,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             st_len_err,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [CNT_W-1:0] cnt_fc,
  input logic [CNT_W-1:0] cnt_und
);
  logic wr_fc, wr_und;
  assign wr_fc  = reg_wr && !reg_sel;
  assign wr_und = reg_wr && reg_sel;

  a_r8_fc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fc |=> cnt_fc >= $past(cnt_fc));
  a_r8_und_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_und |=> cnt_und >= $past(cnt_und));
  a_r2_fc_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fc |=> CNT_W'(cnt_fc - $past(cnt_fc)) <= 1);
  a_r3_fc_waits_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !wr_fc) |=> $stable(cnt_fc));
  a_r4_und_waits_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !wr_und) |=> $stable(cnt_und));
  a_r5_len_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_len_err && !wr_und) |=> $stable(cnt_und));
  a_r7_fc_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fc |=> cnt_fc == $past(reg_wdata[CNT_W-1:0]));
  a_r9_und_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_und |=> cnt_und == $past(reg_wdata[CNT_W-1:0]));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:CNT_W] == '0);
endmodule

bind rx_err_stats rx_err_stats_chk #(.CNT_W(CNT_W), .REG_W(REG_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_len_err(st_len_err),
  .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .cnt_fc(cnt[0]), .cnt_und(cnt[1])
);

// File: tb/tb_rx_err_stats.sv
`timescale 1ns/100ps
module tb_rx_err_stats;
  logic clk = 0, rst_n = 0;
  logic rx_dv = 0, rx_er = 0;
  logic [3:0] rxd = 0;
  logic st_valid = 0, st_fcs_ok = 0, st_well_formed = 0, st_len_err = 0;
  logic [15:0] st_len = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt [2];
  int m_pend = 0, m_lock = 0;
  string cur_req = "R6";
  bit done = 0;

  always #2 clk = ~clk;

  rx_err_stats dut (.*);

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_pend = 0; m_lock = 0;
    end else begin
      bit hit, cap, fc_add, und_add;
      hit     = rx_er && !rx_dv && rxd == 4'hE;
      cap     = hit && (m_lock == 0);
      fc_add  = st_valid && (m_pend != 0);
      und_add = st_valid && st_len < 64 && st_fcs_ok && st_well_formed && !st_len_err;
      if (rx_dv) m_lock = 0; else if (cap) m_lock = 1;
      if (cap) m_pend = 1; else if (st_valid) m_pend = 0;
      for (int i = 0; i < 2; i++) begin
        bit add;
        add = (i == 0) ? fc_add : und_add;
        if (reg_wr && reg_sel == i[0]) m_cnt[i] = int'(reg_wdata[15:0]);
        else if (add && m_cnt[i] < 65535) m_cnt[i] = m_cnt[i] + 1;
      end
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (reg_rdata !== 32'(m_cnt[reg_sel])) begin
        errors++;
        $display("FAIL %s per-cycle sel=%0d actual=%h expected=%h", cur_req, reg_sel,
                 reg_rdata, 32'(m_cnt[reg_sel]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); rx_dv = 0; rx_er = 0; rxd = 0; end
  endtask
  task automatic fc_hit;
    @(negedge clk); rx_dv = 0; rx_er = 1; rxd = 4'hE;
    @(negedge clk); rx_er = 0; rxd = 0;
  endtask
  task automatic frame(int n);
    repeat (n) begin @(negedge clk); rx_dv = 1; rx_er = 0; rxd = 4'h5; end
    @(negedge clk); rx_dv = 0; rxd = 0;
  endtask
  task automatic stat(int len, bit fcs, bit wf, bit lerr);
    @(negedge clk); st_valid = 1; st_len = 16'(len); st_fcs_ok = fcs;
    st_well_formed = wf; st_len_err = lerr;
    @(negedge clk); st_valid = 0;
  endtask
  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic expect_reg(bit sel, logic [31:0] exp, string req);
    @(negedge clk); reg_sel = sel; #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, reg_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R6";
    expect_reg(0, 0, "R6"); expect_reg(1, 0, "R6");
    cur_req = "R7";
    wr(0, 32'hABCD_1234); expect_reg(0, 32'h0000_1234, "R7");
    wr(0, 0); expect_reg(0, 0, "R7");
    // R1: near misses are not hits
    cur_req = "R1";
    @(negedge clk); rx_er = 1; rxd = 4'hD;
    @(negedge clk); rx_er = 0; rxd = 4'hE;
    @(negedge clk); rx_dv = 1; rx_er = 1; rxd = 4'hE;
    idle(2); frame(4); stat(100, 1, 1, 0);
    expect_reg(0, 0, "R1");
    // R3: detection alone does not count
    cur_req = "R3";
    fc_hit(); idle(3); expect_reg(0, 0, "R3");
    frame(5); expect_reg(0, 0, "R3");
    stat(200, 1, 1, 0); expect_reg(0, 1, "R3");
    stat(200, 1, 1, 0); expect_reg(0, 1, "R3");
    // R2: toggling within one gap counts once
    cur_req = "R2";
    fc_hit(); fc_hit(); fc_hit(); frame(3); stat(300, 1, 1, 0);
    expect_reg(0, 2, "R2");
    // R4 undersize qualification
    cur_req = "R4";
    stat(63, 1, 1, 0); expect_reg(1, 1, "R4");
    stat(64, 1, 1, 0); expect_reg(1, 1, "R4");
    stat(10, 0, 1, 0); expect_reg(1, 1, "R4");
    stat(10, 1, 0, 0); expect_reg(1, 1, "R4");
    cur_req = "R5";
    stat(20, 1, 1, 1); expect_reg(1, 1, "R5");
    // R10 back-to-back strobes
    cur_req = "R10";
    @(negedge clk); st_valid = 1; st_len = 30; st_fcs_ok = 1; st_well_formed = 1; st_len_err = 0;
    @(negedge clk); st_len = 40;
    @(negedge clk); st_valid = 0;
    expect_reg(1, 3, "R10");
    // R8 saturation
    cur_req = "R8";
    wr(1, 32'h0000_FFFE);
    stat(5, 1, 1, 0); stat(5, 1, 1, 0); stat(5, 1, 1, 0);
    expect_reg(1, 32'h0000_FFFF, "R8");
    wr(0, 32'h0000_FFFF); fc_hit(); frame(2); stat(500, 1, 1, 0);
    expect_reg(0, 32'h0000_FFFF, "R8");
    // R9 write vs increment collision
    cur_req = "R9";
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_wdata = 32'h5;
    st_valid = 1; st_len = 12; st_fcs_ok = 1; st_well_formed = 1; st_len_err = 0;
    @(negedge clk); reg_wr = 0; st_valid = 0;
    expect_reg(1, 5, "R9");
    fc_hit(); frame(2);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = 32'h7;
    st_valid = 1; st_len = 400; st_fcs_ok = 1; st_well_formed = 1;
    @(negedge clk); reg_wr = 0; st_valid = 0;
    expect_reg(0, 7, "R9");
    frame(2); stat(400, 1, 1, 0); expect_reg(0, 7, "R9");
    // R6 reset clears
    cur_req = "R6";
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    expect_reg(0, 0, "R6"); expect_reg(1, 0, "R6");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule